// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge and Vector Unit

This unit sits between two 8-line interrupt cores wired in cascade (a primary core and a secondary core whose output shares primary line 2) and the CPU. Each core reports whether it holds a deliverable interrupt and which line wins. The unit forwards the secondary core's request to primary line 2 as a short high-then-low pulse, so that the primary core can latch it as an edge. It drives a single interrupt request toward the CPU.

When the CPU strobes acknowledge, the unit decides which core supplies the vector. It strobes acknowledge into the winning core or cores and returns an 8-bit vector. The vector is the winner's programmed base with its low three bits cleared, plus the line number. It also returns the combined interrupt number: 0 to 7 for primary lines and 8 to 15 for secondary lines. If the CPU acknowledges when no request is present at either level, the unit substitutes line 7 of the level concerned.

Top module: `ivu_top`

## Requirements
- R1: While `slv_pend` is high, `cas_pulse` goes high in the cycle after the request is seen and then alternates high and low. It is low in any cycle that follows a cycle in which `slv_pend` was low.
- R2: Outside the cycle that follows an acknowledge, `cpu_irq` equals the value `mst_pend` had in the previous cycle.
- R3: An acknowledge while `mst_pend` is high and `mst_line` is not 2 does four things. It strobes `mst_ack_stb` with `mst_ack_line` equal to `mst_line`. It gives a vector equal to the primary base plus `mst_line`. It gives `irq_num` equal to `mst_line`. It does not strobe `slv_ack_stb`.
- R4: An acknowledge while `mst_pend` is high, `mst_line` is 2 and `slv_pend` is high does four things. It strobes `mst_ack_stb` with line 2. It strobes `slv_ack_stb` with `slv_ack_line` equal to `slv_line`. It gives a vector equal to the secondary base plus `slv_line`. It gives `irq_num` equal to 8 plus `slv_line`.
- R5: An acknowledge while `mst_pend` is high, `mst_line` is 2 and `slv_pend` is low strobes `mst_ack_stb` with line 2 and does not strobe `slv_ack_stb`. It gives a vector equal to the secondary base plus 7 and `irq_num` equal to 15.
- R6: An acknowledge while `mst_pend` is low strobes neither core. It gives a vector equal to the primary base plus 7 and `irq_num` equal to 7.
- R7: A base is the programmed configuration byte with bits 2..0 forced to zero (value AND 0xF8).
- R8: `vec_valid` is high for exactly the cycle after each cycle in which `cpu_ack` is high. Both acknowledge strobes are high only in such a cycle, and `vec_out` and `irq_num` are meaningful only then.
- R9: `cpu_irq` is low in the cycle after an acknowledge. From the next cycle on it again follows R2, so a request that now outranks the others can be raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_pend | input | 1 | Primary core has a deliverable interrupt |
| mst_line | input | 3 | Primary core winning line |
| slv_pend | input | 1 | Secondary core has a deliverable interrupt |
| slv_line | input | 3 | Secondary core winning line |
| mst_base_cfg | input | 8 | Programmed primary vector base byte |
| slv_base_cfg | input | 8 | Programmed secondary vector base byte |
| cpu_ack | input | 1 | CPU acknowledge strobe |
| cpu_irq | output | 1 | Interrupt request toward the CPU |
| cas_pulse | output | 1 | Pulse into primary line 2 |
| mst_ack_stb | output | 1 | Acknowledge strobe into the primary core |
| mst_ack_line | output | 3 | Line acknowledged in the primary core |
| slv_ack_stb | output | 1 | Acknowledge strobe into the secondary core |
| slv_ack_line | output | 3 | Line acknowledged in the secondary core |
| vec_valid | output | 1 | Vector result valid pulse |
| vec_out | output | 8 | Returned vector |
| irq_num | output | 4 | Combined interrupt number 0..15 |

## Verification
Acknowledges are issued with the primary winner on an ordinary line, on the cascade line with a secondary winner, and on the cascade line with the secondary idle. Acknowledges are also issued with the primary idle. The four outcomes differ in which strobes fire and which base and line form the vector. Bases with nonzero low bits are programmed, so that a design that fails to clear bits 2..0 gives a wrong vector. The request output is watched around an acknowledge to separate the forced-low cycle from ordinary tracking. The cascade pulse is watched under a held secondary request to confirm that it toggles rather than holds.

// File: rtl/ivu_pkg.sv
// Package: shared widths and the acknowledge result record for the
// cascaded acknowledge and vector unit. Assumes two levels of equal width.
package ivu_pkg;
    localparam int LINES     = 8;
    localparam int LINE_W    = $clog2(LINES);
    localparam int VEC_W     = 8;
    localparam int NUM_W     = LINE_W + 1;
    localparam int CAS_LINE  = 2;
    localparam int SPUR_LINE = LINES - 1;

    typedef struct packed {
        logic              mst_stb;
        logic              slv_stb;
        logic [LINE_W-1:0] mst_line;
        logic [LINE_W-1:0] slv_line;
        logic [VEC_W-1:0]  vec;
        logic [NUM_W-1:0]  num;
    } ack_res_t;
endpackage

// File: rtl/ivu_cascade_link.sv
// Module: forwards the secondary request into the primary cascade line
// as alternating high/low pulses so the primary latches an edge.
// Assumes the primary samples its cascade line as edge-triggered.
module ivu_cascade_link (
    input  logic clk,
    input  logic rst_n,
    input  logic slv_pend,
    output logic cas_pulse
);
    // Toggle high then low for as long as the secondary request stays up.
    always_ff @(posedge clk) begin
        if (!rst_n) cas_pulse <= 1'b0;
        else        cas_pulse <= slv_pend & ~cas_pulse;
    end
endmodule

// File: rtl/ivu_vector_sel.sv
// Module: combinational two-level acknowledge decision. Picks which core
// is acknowledged and forms the vector and combined number, with line 7
// used as fallback for an empty level. Assumes winner lines are stable
// in the cycle the acknowledge is sampled.
module ivu_vector_sel
    import ivu_pkg::*;
(
    input  logic              mst_pend,
    input  logic [LINE_W-1:0] mst_line,
    input  logic              slv_pend,
    input  logic [LINE_W-1:0] slv_line,
    input  logic [VEC_W-1:0]  mst_base_cfg,
    input  logic [VEC_W-1:0]  slv_base_cfg,
    output ack_res_t          res
);
    localparam logic [VEC_W-1:0] LOW_MASK = VEC_W'((1 << LINE_W) - 1);
    localparam logic [LINE_W-1:0] CAS  = LINE_W'(CAS_LINE);
    localparam logic [LINE_W-1:0] SPUR = LINE_W'(SPUR_LINE);

    logic [VEC_W-1:0] cfg  [2];
    logic [VEC_W-1:0] base [2];

    assign cfg[0] = mst_base_cfg;
    assign cfg[1] = slv_base_cfg;

    // One base-masking stage per level.
    for (genvar g = 0; g < 2; g++) begin : g_base
        assign base[g] = cfg[g] & ~LOW_MASK;
    end

    // Decide strobes, vector and combined number for this acknowledge.
    always_comb begin
        res = '0;
        if (!mst_pend) begin
            res.vec = base[0] | VEC_W'(SPUR);
            res.num = {1'b0, SPUR};
        end else if (mst_line != CAS) begin
            res.mst_stb  = 1'b1;
            res.mst_line = mst_line;
            res.vec      = base[0] | VEC_W'(mst_line);
            res.num      = {1'b0, mst_line};
        end else begin
            res.mst_stb  = 1'b1;
            res.mst_line = CAS;
            if (slv_pend) begin
                res.slv_stb  = 1'b1;
                res.slv_line = slv_line;
                res.vec      = base[1] | VEC_W'(slv_line);
                res.num      = {1'b1, slv_line};
            end else begin
                res.vec = base[1] | VEC_W'(SPUR);
                res.num = {1'b1, SPUR};
            end
        end
    end
endmodule

// File: rtl/ivu_ack_stage.sv
// Module: registers the acknowledge result into one-cycle strobes and
// produces the CPU request, held low the cycle after an acknowledge so
// the cores' updated state is re-evaluated. Assumes cpu_ack is sampled
// once per cycle.
module ivu_ack_stage
    import ivu_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cpu_ack,
    input  logic     mst_pend,
    input  ack_res_t res,
    output logic     cpu_irq,
    output logic     vec_valid,
    output ack_res_t res_q
);
    // Capture the decision and the valid pulse on each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            vec_valid <= cpu_ack;
            if (cpu_ack) res_q <= res;
            else         res_q <= '0;
        end
    end

    // Request follows the primary pending flag, dropped after an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_irq <= 1'b0;
        else        cpu_irq <= mst_pend & ~cpu_ack;
    end
endmodule

// File: rtl/ivu_top.sv
// Module: cascaded interrupt acknowledge and vector unit top. Connects
// the cascade pulse link, the two-level vector decision and the output
// register stage. Assumes both cores report pending/winner combinationally.
module ivu_top
    import ivu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mst_pend,
    input  logic [LINE_W-1:0] mst_line,
    input  logic              slv_pend,
    input  logic [LINE_W-1:0] slv_line,
    input  logic [VEC_W-1:0]  mst_base_cfg,
    input  logic [VEC_W-1:0]  slv_base_cfg,
    input  logic              cpu_ack,
    output logic              cpu_irq,
    output logic              cas_pulse,
    output logic              mst_ack_stb,
    output logic [LINE_W-1:0] mst_ack_line,
    output logic              slv_ack_stb,
    output logic [LINE_W-1:0] slv_ack_line,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_out,
    output logic [NUM_W-1:0]  irq_num
);
    ack_res_t res_d;
    ack_res_t res_q;

    ivu_cascade_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .slv_pend  (slv_pend),
        .cas_pulse (cas_pulse)
    );

    ivu_vector_sel u_sel (
        .mst_pend     (mst_pend),
        .mst_line     (mst_line),
        .slv_pend     (slv_pend),
        .slv_line     (slv_line),
        .mst_base_cfg (mst_base_cfg),
        .slv_base_cfg (slv_base_cfg),
        .res          (res_d)
    );

    ivu_ack_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_ack   (cpu_ack),
        .mst_pend  (mst_pend),
        .res       (res_d),
        .cpu_irq   (cpu_irq),
        .vec_valid (vec_valid),
        .res_q     (res_q)
    );

    // Unpack the registered record onto the ports.
    always_comb begin
        mst_ack_stb  = res_q.mst_stb;
        mst_ack_line = res_q.mst_line;
        slv_ack_stb  = res_q.slv_stb;
        slv_ack_line = res_q.slv_line;
        vec_out      = res_q.vec;
        irq_num      = res_q.num;
    end
endmodule

// File: rtl/ivu_checker.sv
// Module: property checker for ivu_top, bound to every instance.
// Assumes synchronous active-low reset; past_ok gates $past use.
module ivu_checker
    import ivu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mst_pend,
    input logic              slv_pend,
    input logic [VEC_W-1:0]  slv_base_cfg,
    input logic              cpu_ack,
    input logic              cpu_irq,
    input logic              cas_pulse,
    input logic              mst_ack_stb,
    input logic [LINE_W-1:0] mst_ack_line,
    input logic              slv_ack_stb,
    input logic              vec_valid,
    input logic [VEC_W-1:0]  vec_out,
    input logic [NUM_W-1:0]  irq_num
);
    logic past_ok;

    // Marks that one full cycle out of reset has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_CAS_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        cas_pulse |=> !cas_pulse); // R1
    AST_CAS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(slv_pend)) |-> !cas_pulse); // R1
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(cpu_ack)) |-> (cpu_irq == $past(mst_pend))); // R2
    AST_IRQ_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cpu_ack)) |-> !cpu_irq); // R9
    AST_VALID_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (vec_valid == $past(cpu_ack))); // R8
    AST_STB_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_ack_stb || slv_ack_stb) |-> vec_valid); // R8
    AST_SLV_VIA_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        slv_ack_stb |-> (mst_ack_stb && mst_ack_line == LINE_W'(CAS_LINE))); // R4
    AST_SPUR_IS_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !mst_ack_stb) |-> (irq_num == NUM_W'(SPUR_LINE))); // R6
    AST_SLV_BASE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && vec_valid && irq_num[NUM_W-1])
        |-> (vec_out[VEC_W-1:LINE_W] == $past(slv_base_cfg[VEC_W-1:LINE_W]))); // R7
endmodule

bind ivu_top ivu_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mst_pend     (mst_pend),
    .slv_pend     (slv_pend),
    .slv_base_cfg (slv_base_cfg),
    .cpu_ack      (cpu_ack),
    .cpu_irq      (cpu_irq),
    .cas_pulse    (cas_pulse),
    .mst_ack_stb  (mst_ack_stb),
    .mst_ack_line (mst_ack_line),
    .slv_ack_stb  (slv_ack_stb),
    .vec_valid    (vec_valid),
    .vec_out      (vec_out),
    .irq_num      (irq_num)
);

// File: tb/sim_ivu_top.sv
module sim_ivu_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mst_pend = 1'b0;
    logic [2:0] mst_line = '0;
    logic       slv_pend = 1'b0;
    logic [2:0] slv_line = '0;
    logic [7:0] mst_base_cfg = '0;
    logic [7:0] slv_base_cfg = '0;
    logic       cpu_ack = 1'b0;
    logic       cpu_irq, cas_pulse, mst_ack_stb, slv_ack_stb, vec_valid;
    logic [2:0] mst_ack_line, slv_ack_line;
    logic [7:0] vec_out;
    logic [3:0] irq_num;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string      req;
        logic       m_stb;
        logic [2:0] m_line;
        logic       s_stb;
        logic [2:0] s_line;
        logic [7:0] vec;
        logic [3:0] num;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    ivu_top u0 (
        .clk(clk), .rst_n(rst_n), .mst_pend(mst_pend), .mst_line(mst_line),
        .slv_pend(slv_pend), .slv_line(slv_line), .mst_base_cfg(mst_base_cfg),
        .slv_base_cfg(slv_base_cfg), .cpu_ack(cpu_ack), .cpu_irq(cpu_irq),
        .cas_pulse(cas_pulse), .mst_ack_stb(mst_ack_stb), .mst_ack_line(mst_ack_line),
        .slv_ack_stb(slv_ack_stb), .slv_ack_line(slv_ack_line), .vec_valid(vec_valid),
        .vec_out(vec_out), .irq_num(irq_num)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: set core state, queue the expected result, strobe acknowledge.
    task automatic do_ack(string req, logic mp, logic [2:0] ml, logic sp, logic [2:0] sl);
        exp_t e;
        logic [7:0] mb, xb;
        mb = mst_base_cfg & 8'hF8;
        xb = slv_base_cfg & 8'hF8;
        e.req = req; e.m_stb = 0; e.m_line = 0; e.s_stb = 0; e.s_line = 0;
        if (!mp) begin
            e.vec = mb + 8'd7; e.num = 4'd7;
        end else if (ml != 3'd2) begin
            e.m_stb = 1; e.m_line = ml; e.vec = mb + 8'(ml); e.num = {1'b0, ml};
        end else if (sp) begin
            e.m_stb = 1; e.m_line = 3'd2; e.s_stb = 1; e.s_line = sl;
            e.vec = xb + 8'(sl); e.num = 4'd8 + 4'(sl);
        end else begin
            e.m_stb = 1; e.m_line = 3'd2; e.vec = xb + 8'd7; e.num = 4'd15;
        end
        @(negedge clk);
        mst_pend = mp; mst_line = ml; slv_pend = sp; slv_line = sl;
        cpu_ack = 1'b1;
        sb.push_back(e);
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    // Monitor: compare each produced result against the queue head.
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (sb.size() == 0) begin
                chk("R8 unexpected valid", 16'd1, 16'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.req, " vec"}, 16'(vec_out), 16'(e.vec));
                chk({e.req, " num"}, 16'(irq_num), 16'(e.num));
                chk({e.req, " mst strobe/line"}, {12'd0, mst_ack_stb, mst_ack_line},
                    {12'd0, e.m_stb, e.m_line});
                chk({e.req, " slv strobe/line"}, {12'd0, slv_ack_stb, slv_ack_line},
                    {12'd0, e.s_stb, e.s_line});
            end
        end else if (rst_n) begin
            if (mst_ack_stb || slv_ack_stb) chk("R8 strobe outside valid", 16'd1, 16'd0);
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset irq", 16'(cpu_irq), 16'd0);
        chk("R1 reset cascade", 16'(cas_pulse), 16'd0);
        chk("R8 reset valid", 16'(vec_valid), 16'd0);

        mst_base_cfg = 8'h27;   // R7: low bits must be dropped
        slv_base_cfg = 8'h7F;

        // R2: request follows primary pending one cycle later
        mst_pend = 1'b1; mst_line = 3'd4;
        @(negedge clk);
        chk("R2 irq rise", 16'(cpu_irq), 16'd1);
        mst_pend = 1'b0;
        @(negedge clk);
        chk("R2 irq fall", 16'(cpu_irq), 16'd0);

        // R1: held secondary request toggles the cascade pulse
        slv_pend = 1'b1;
        @(negedge clk);
        chk("R1 pulse high", 16'(cas_pulse), 16'd1);
        @(negedge clk);
        chk("R1 pulse low", 16'(cas_pulse), 16'd0);
        @(negedge clk);
        chk("R1 pulse high again", 16'(cas_pulse), 16'd1);
        slv_pend = 1'b0;
        @(negedge clk);
        chk("R1 idle low", 16'(cas_pulse), 16'd0);
        @(negedge clk);
        chk("R1 stays low", 16'(cas_pulse), 16'd0);

        do_ack("R3 primary line 5 R7", 1'b1, 3'd5, 1'b0, 3'd0);
        do_ack("R3 primary line 0", 1'b1, 3'd0, 1'b1, 3'd6);
        do_ack("R4 cascade slave line 3 R7", 1'b1, 3'd2, 1'b1, 3'd3);
        do_ack("R4 cascade slave line 0", 1'b1, 3'd2, 1'b1, 3'd0);
        do_ack("R5 cascade slave spurious", 1'b1, 3'd2, 1'b0, 3'd4);
        do_ack("R6 primary spurious", 1'b0, 3'd3, 1'b0, 3'd0);

        mst_base_cfg = 8'h08; slv_base_cfg = 8'hF0;
        do_ack("R3 primary line 7 new base", 1'b1, 3'd7, 1'b0, 3'd0);
        do_ack("R4 cascade slave line 7 new base", 1'b1, 3'd2, 1'b1, 3'd7);

        // R9: request dropped the cycle after acknowledge, then re-evaluated
        mst_pend = 1'b1; mst_line = 3'd1;
        @(negedge clk);
        chk("R9 irq before ack", 16'(cpu_irq), 16'd1);
        do_ack("R3 ack around irq", 1'b1, 3'd1, 1'b0, 3'd0);
        chk("R9 irq low after ack", 16'(cpu_irq), 16'd0);
        @(negedge clk);
        chk("R9 irq re-raised", 16'(cpu_irq), 16'd1);
        mst_pend = 1'b0; slv_pend = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 queue drained", 16'(sb.size()), 16'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule